// File: doc/BRIEF.md
# Nonvolatile Transfer Sequencer

This controller decides when a working SRAM is copied into its shadow nonvolatile array (store) and when the array is copied back (recall). It keeps track of whether the SRAM has been written since the last transfer. It watches four sources of requests:

- an open-drain busy line that an outside agent can pull low;
- a supply-fail flag that triggers an automatic store;
- a supply-good flag that triggers a power-up recall;
- single-cycle software pulses from an address-sequence decoder.

While a transfer runs, the controller pulls the busy line low and raises a host inhibit that blocks new host reads and writes. It also tells a behavioural array model which operation to perform, when each phase starts and when the transfer ends.

The busy line enters through a configurable synchronizer. The block models the open-drain pin as two enables: one pulls the line low, the other drives it actively high. Whatever the busy line carries when left undriven comes from a weak pull-up outside the block. All durations are cycle-count parameters: the grace window for a write already in flight, the active-high drive time, the store time and the two recall phases.

Top module: `nvx_seq`

## Requirements
- R1: While reset is asserted and after it is released, the state output reads 6 (power-down), host_inhibit_o is 1 and neither busy enable is active. The block stays in state 6 for as long as supply_good_i is 0.
- R2: A recall starts from state 6 one cycle after supply_good_i is 1 with supply_fail_i at 0.
  - It first holds state 7 for RCL_CLR_CYC cycles with arr_op_o = 2 (clear), then state 8 for RCL_LOAD_CYC cycles with arr_op_o = 3 (load).
  - The busy line is pulled low throughout.
  - arr_start_o pulses in the first cycle of each phase, and arr_done_o pulses in the first cycle after the load phase.
- R3: A dirty flag is set one cycle after wr_done_i. It is cleared when a store or a recall ends.
- R4: In idle, a low busy line is seen SYNC_STAGES+1 cycles after it falls. If the dirty flag is set, the block then enters state 1 (grace) for DELAY_CYC cycles and state 2 (store, arr_op_o = 1) for STORE_CYC cycles, pulling the line low in both states. arr_start_o marks the first store cycle and arr_done_o the cycle after the last.
- R5: A low busy line seen in idle while the dirty flag is clear leads to state 5. In state 5 the block drives nothing on the line and keeps host_inhibit_o high. It returns to idle SYNC_STAGES+1 cycles after the line rises.
- R6: A sw_store_i pulse in idle enters state 1 on the next cycle whatever the dirty flag holds, and then runs a full store.
- R7: A store that was started by the busy line or by software ends with state 3. State 3 lasts HOLD_HI_CYC cycles, with busy_push_hi_o at 1 and busy_pull_lo_o at 0. The two busy enables are never active together.
- R8: After the active-high drive, the block holds state 4 for as long as the synchronized line reads low. It returns to idle SYNC_STAGES+1 cycles after the line rises.
- R9: supply_fail_i in idle starts an automatic store (state 1 on the next cycle) only when both the dirty flag and the automatic-store enable are set; otherwise the block enters state 6 directly. An automatic store ends in state 6 with no active-high drive.
- R10: The automatic-store enable is set at reset. An ase_off_i pulse clears it and an ase_on_i pulse sets it, each from the next cycle.
- R11: After its own low drive ends, the block passes through state 4 until the synchronized line reads high. The release of its own drive is therefore never taken for a new outside request.
- R12: host_inhibit_o is 1 in every state except idle (state 0).
- R13: A sw_recall_i pulse in idle runs the recall of R2, starting the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_line_i | input | 1 | Resolved level of the busy line |
| busy_pull_lo_o | output | 1 | Pulls the busy line low |
| busy_push_hi_o | output | 1 | Drives the busy line actively high |
| supply_fail_i | input | 1 | Supply is failing; automatic store request |
| supply_good_i | input | 1 | Supply is within range |
| sw_store_i | input | 1 | Software store pulse |
| sw_recall_i | input | 1 | Software recall pulse |
| ase_on_i | input | 1 | Sets the automatic-store enable |
| ase_off_i | input | 1 | Clears the automatic-store enable |
| wr_done_i | input | 1 | A host SRAM write has completed |
| host_inhibit_o | output | 1 | Blocks host reads and writes |
| arr_op_o | output | 2 | Array operation: 0 none, 1 store, 2 clear, 3 load |
| arr_start_o | output | 1 | First cycle of an array phase |
| arr_done_o | output | 1 | Store or recall has finished |
| state_o | output | 4 | Sequencer state code |

## Verification
Each result arrives a fixed number of cycles after its cause:

- Any control pulse moves the state output one cycle later.
- A change on the busy line takes SYNC_STAGES+1 cycles, because the synchronizer sits in front of the state register.
- Each phase lasts exactly its parameter count. Phase boundaries therefore fall at cycle offsets that add up: grace plus store plus active-high drive, or clear plus load plus the synchronizer delay.

The driver works these offsets out from the requirements when it applies a stimulus. It files each expected value under the exact cycle at which it is due. The monitor compares the port value at the falling edge of that cycle, so a result that arrives early or late fails in the same way as a wrong one.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_GRACE    = 4'd1,
      ST_STORE    = 4'd2,
      ST_HOLD_HI  = 4'd3,
      ST_WAIT_REL = 4'd4,
      ST_EXT_HOLD = 4'd5,
      ST_PWR_DOWN = 4'd6,
      ST_RCL_CLR  = 4'd7,
      ST_RCL_LOAD = 4'd8
   } seq_state_t;

   typedef enum logic [1:0] {
      KIND_HW   = 2'd0,
      KIND_SW   = 2'd1,
      KIND_AUTO = 2'd2
   } store_kind_t;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_STORE = 2'd1,
      OP_CLEAR = 2'd2,
      OP_LOAD  = 2'd3
   } arr_op_t;

endpackage

// File: rtl/nvx_busy_sync.sv
module nvx_busy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign line_s_o = line_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;
            end else begin
               chain_q[0] <= line_i;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign line_s_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nvx_timer.sv
module nvx_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TW'(1);
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nvx_flags.sv
module nvx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_done_i,
   input  logic clr_dirty_i,
   input  logic ase_on_i,
   input  logic ase_off_i,
   output logic dirty_o,
   output logic ase_o
);

   logic dirty_q;
   logic ase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dirty_q <= 1'b0;
         ase_q   <= 1'b1;
      end else begin
         if (clr_dirty_i)    dirty_q <= 1'b0;
         else if (wr_done_i) dirty_q <= 1'b1;
         if (ase_off_i)      ase_q <= 1'b0;
         else if (ase_on_i)  ase_q <= 1'b1;
      end
   end

   assign dirty_o = dirty_q;
   assign ase_o   = ase_q;

endmodule

// File: rtl/nvx_ctrl.sv
module nvx_ctrl
   import nvx_pkg::*;
#(
   parameter int DELAY_CYC    = 4,
   parameter int HOLD_HI_CYC  = 8,
   parameter int STORE_CYC    = 64,
   parameter int RCL_CLR_CYC  = 8,
   parameter int RCL_LOAD_CYC = 32,
   parameter int TW           = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          supply_fail_i,
   input  logic          supply_good_i,
   input  logic          sw_store_i,
   input  logic          sw_recall_i,
   input  logic          line_s_i,
   input  logic          dirty_i,
   input  logic          ase_i,
   input  logic          zero_i,
   output logic          tmr_load_o,
   output logic [TW-1:0] tmr_val_o,
   output logic          clr_dirty_o,
   output logic          busy_pull_lo_o,
   output logic          busy_push_hi_o,
   output logic          host_inhibit_o,
   output logic [1:0]    arr_op_o,
   output logic          arr_start_o,
   output logic          arr_done_o,
   output logic [3:0]    state_o
);

   localparam logic [TW-1:0] GRACE_V = TW'(DELAY_CYC - 1);
   localparam logic [TW-1:0] STORE_V = TW'(STORE_CYC - 1);
   localparam logic [TW-1:0] HOLD_V  = TW'(HOLD_HI_CYC - 1);
   localparam logic [TW-1:0] CLR_V   = TW'(RCL_CLR_CYC - 1);
   localparam logic [TW-1:0] LOAD_V  = TW'(RCL_LOAD_CYC - 1);

   seq_state_t  st_q, nxt;
   store_kind_t kind_q, kind_d;
   logic        start_q, done_q;

   always_comb begin
      nxt         = st_q;
      kind_d      = kind_q;
      tmr_load_o  = 1'b0;
      tmr_val_o   = '0;
      clr_dirty_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (supply_fail_i) begin
               if (ase_i && dirty_i) begin
                  nxt = ST_GRACE; kind_d = KIND_AUTO;
                  tmr_load_o = 1'b1; tmr_val_o = GRACE_V;
               end else begin
                  nxt = ST_PWR_DOWN;
               end
            end else if (!supply_good_i) begin
               nxt = ST_PWR_DOWN;
            end else if (sw_store_i) begin
               nxt = ST_GRACE; kind_d = KIND_SW;
               tmr_load_o = 1'b1; tmr_val_o = GRACE_V;
            end else if (!line_s_i) begin
               if (dirty_i) begin
                  nxt = ST_GRACE; kind_d = KIND_HW;
                  tmr_load_o = 1'b1; tmr_val_o = GRACE_V;
               end else begin
                  nxt = ST_EXT_HOLD;
               end
            end else if (sw_recall_i) begin
               nxt = ST_RCL_CLR;
               tmr_load_o = 1'b1; tmr_val_o = CLR_V;
            end
         end
         ST_GRACE: if (zero_i) begin
            nxt = ST_STORE;
            tmr_load_o = 1'b1; tmr_val_o = STORE_V;
         end
         ST_STORE: if (zero_i) begin
            clr_dirty_o = 1'b1;
            if (kind_q == KIND_AUTO) begin
               nxt = ST_PWR_DOWN;
            end else begin
               nxt = ST_HOLD_HI;
               tmr_load_o = 1'b1; tmr_val_o = HOLD_V;
            end
         end
         ST_HOLD_HI:  if (zero_i) nxt = ST_WAIT_REL;
         ST_WAIT_REL: if (line_s_i) nxt = ST_IDLE;
         ST_EXT_HOLD: if (line_s_i) nxt = ST_IDLE;
         ST_PWR_DOWN: if (supply_good_i && !supply_fail_i) begin
            nxt = ST_RCL_CLR;
            tmr_load_o = 1'b1; tmr_val_o = CLR_V;
         end
         ST_RCL_CLR: if (zero_i) begin
            nxt = ST_RCL_LOAD;
            tmr_load_o = 1'b1; tmr_val_o = LOAD_V;
         end
         ST_RCL_LOAD: if (zero_i) begin
            clr_dirty_o = 1'b1;
            nxt = ST_WAIT_REL;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_PWR_DOWN;
         kind_q  <= KIND_HW;
         start_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         st_q    <= nxt;
         kind_q  <= kind_d;
         start_q <= tmr_load_o &&
                    (nxt == ST_STORE || nxt == ST_RCL_CLR || nxt == ST_RCL_LOAD);
         done_q  <= zero_i && (st_q == ST_STORE || st_q == ST_RCL_LOAD);
      end
   end

   always_comb begin
      unique case (st_q)
         ST_STORE:    arr_op_o = OP_STORE;
         ST_RCL_CLR:  arr_op_o = OP_CLEAR;
         ST_RCL_LOAD: arr_op_o = OP_LOAD;
         default:     arr_op_o = OP_NONE;
      endcase
   end

   assign busy_pull_lo_o = (st_q == ST_GRACE) || (st_q == ST_STORE) ||
                           (st_q == ST_RCL_CLR) || (st_q == ST_RCL_LOAD);
   assign busy_push_hi_o = (st_q == ST_HOLD_HI);
   assign host_inhibit_o = (st_q != ST_IDLE);
   assign arr_start_o    = start_q;
   assign arr_done_o     = done_q;
   assign state_o        = st_q;

endmodule

// File: rtl/nvx_seq.sv
module nvx_seq #(
   parameter int DELAY_CYC    = 4,
   parameter int HOLD_HI_CYC  = 8,
   parameter int STORE_CYC    = 64,
   parameter int RCL_CLR_CYC  = 8,
   parameter int RCL_LOAD_CYC = 32,
   parameter int RCL_MAX_CYC  = 2_500_000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       busy_line_i,
   output logic       busy_pull_lo_o,
   output logic       busy_push_hi_o,
   input  logic       supply_fail_i,
   input  logic       supply_good_i,
   input  logic       sw_store_i,
   input  logic       sw_recall_i,
   input  logic       ase_on_i,
   input  logic       ase_off_i,
   input  logic       wr_done_i,
   output logic       host_inhibit_o,
   output logic [1:0] arr_op_o,
   output logic       arr_start_o,
   output logic       arr_done_o,
   output logic [3:0] state_o
);

   localparam int MAX_A   = (DELAY_CYC > HOLD_HI_CYC) ? DELAY_CYC : HOLD_HI_CYC;
   localparam int MAX_B   = (STORE_CYC > RCL_CLR_CYC) ? STORE_CYC : RCL_CLR_CYC;
   localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_CYC = (MAX_C > RCL_LOAD_CYC) ? MAX_C : RCL_LOAD_CYC;
   localparam int TW      = $clog2(MAX_CYC + 1);

   initial begin
      if (DELAY_CYC < 1 || HOLD_HI_CYC < 1 || STORE_CYC < 1 ||
          RCL_CLR_CYC < 1 || RCL_LOAD_CYC < 1)
         $error("nvx_seq: every duration must be at least one cycle");
      if (RCL_CLR_CYC + RCL_LOAD_CYC > RCL_MAX_CYC)
         $error("nvx_seq: recall phases exceed the recall bound");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("nvx_seq: SYNC_STAGES must lie in 0..4");
   end

   logic          line_s;
   logic          dirty_w;
   logic          ase_w;
   logic          clr_dirty;
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_zero;

   nvx_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (busy_line_i),
      .line_s_o (line_s)
   );

   nvx_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_done_i   (wr_done_i),
      .clr_dirty_i (clr_dirty),
      .ase_on_i    (ase_on_i),
      .ase_off_i   (ase_off_i),
      .dirty_o     (dirty_w),
      .ase_o       (ase_w)
   );

   nvx_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   nvx_ctrl #(
      .DELAY_CYC    (DELAY_CYC),
      .HOLD_HI_CYC  (HOLD_HI_CYC),
      .STORE_CYC    (STORE_CYC),
      .RCL_CLR_CYC  (RCL_CLR_CYC),
      .RCL_LOAD_CYC (RCL_LOAD_CYC),
      .TW           (TW)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .supply_fail_i  (supply_fail_i),
      .supply_good_i  (supply_good_i),
      .sw_store_i     (sw_store_i),
      .sw_recall_i    (sw_recall_i),
      .line_s_i       (line_s),
      .dirty_i        (dirty_w),
      .ase_i          (ase_w),
      .zero_i         (tmr_zero),
      .tmr_load_o     (tmr_load),
      .tmr_val_o      (tmr_val),
      .clr_dirty_o    (clr_dirty),
      .busy_pull_lo_o (busy_pull_lo_o),
      .busy_push_hi_o (busy_push_hi_o),
      .host_inhibit_o (host_inhibit_o),
      .arr_op_o       (arr_op_o),
      .arr_start_o    (arr_start_o),
      .arr_done_o     (arr_done_o),
      .state_o        (state_o)
   );

endmodule

// File: rtl/nvx_seq_chk.sv
module nvx_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy_pull_lo_o,
   input logic       busy_push_hi_o,
   input logic       supply_fail_i,
   input logic       supply_good_i,
   input logic       sw_store_i,
   input logic       wr_done_i,
   input logic       host_inhibit_o,
   input logic [1:0] arr_op_o,
   input logic       arr_start_o,
   input logic       arr_done_o,
   input logic [3:0] state_o,
   input logic       dirty,
   input logic       ase
);

   // R7
   drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_pull_lo_o && busy_push_hi_o));

   // R4
   store_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd2 && $past(state_o) == 4'd1) |-> (arr_start_o && arr_op_o == 2'd1));

   // R2
   load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd8) |=> (state_o == 4'd8 || arr_done_o));

   // R5
   ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd5) |-> (!busy_pull_lo_o && !busy_push_hi_o && host_inhibit_o));

   // R6
   sw_store_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd0 && sw_store_i && supply_good_i && !supply_fail_i) |=> (state_o == 4'd1));

   // R1
   pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd6 && !supply_good_i) |=> (state_o == 4'd6));

   // R9
   auto_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 4'd0 && supply_fail_i && dirty && ase) |=> (state_o == 4'd1));

   // R3
   dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done_i && state_o == 4'd0) |=> dirty);

endmodule

bind nvx_seq nvx_seq_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy_pull_lo_o (busy_pull_lo_o),
   .busy_push_hi_o (busy_push_hi_o),
   .supply_fail_i  (supply_fail_i),
   .supply_good_i  (supply_good_i),
   .sw_store_i     (sw_store_i),
   .wr_done_i      (wr_done_i),
   .host_inhibit_o (host_inhibit_o),
   .arr_op_o       (arr_op_o),
   .arr_start_o    (arr_start_o),
   .arr_done_o     (arr_done_o),
   .state_o        (state_o),
   .dirty          (dirty_w),
   .ase            (ase_w)
);

// File: tb/test_nvx_seq.sv
module test_nvx_seq;

   localparam int DLY = 4;
   localparam int HHI = 8;
   localparam int STO = 64;
   localparam int CLR = 8;
   localparam int LDC = 32;
   localparam int SYN = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       ext_low;
   logic       busy_line;
   logic       pull_lo, push_hi;
   logic       supply_fail, supply_good;
   logic       sw_store, sw_recall, ase_on, ase_off, wr_done;
   logic       inhibit;
   logic [1:0] arr_op;
   logic       arr_start, arr_done;
   logic [3:0] state;

   always #4 clk = ~clk;

   assign busy_line = (ext_low || pull_lo) ? 1'b0 : 1'b1;

   nvx_seq #(
      .DELAY_CYC(DLY), .HOLD_HI_CYC(HHI), .STORE_CYC(STO),
      .RCL_CLR_CYC(CLR), .RCL_LOAD_CYC(LDC), .SYNC_STAGES(SYN)
   ) i_nvx_seq (
      .clk(clk), .rst_n(rst_n), .busy_line_i(busy_line),
      .busy_pull_lo_o(pull_lo), .busy_push_hi_o(push_hi),
      .supply_fail_i(supply_fail), .supply_good_i(supply_good),
      .sw_store_i(sw_store), .sw_recall_i(sw_recall),
      .ase_on_i(ase_on), .ase_off_i(ase_off), .wr_done_i(wr_done),
      .host_inhibit_o(inhibit), .arr_op_o(arr_op),
      .arr_start_o(arr_start), .arr_done_o(arr_done), .state_o(state)
   );

   typedef struct {
      int    at;
      int    sel;
      int    val;
      string tag;
   } exp_t;

   exp_t sb_q[$];
   int   cyc   = 0;
   int   total = 0;
   int   bad   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int probe(int sel);
      case (sel)
         0: return int'(state);
         1: return int'(inhibit);
         2: return int'(pull_lo);
         3: return int'(push_hi);
         4: return int'(arr_op);
         5: return int'(arr_start);
         default: return int'(arr_done);
      endcase
   endfunction

   task automatic expect_at(int dly, int sel, int val, string tag);
      exp_t e;
      e.at = cyc + dly; e.sel = sel; e.val = val; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic check_now(int sel, int val, string tag);
      int act;
      act = probe(sel);
      total++;
      if (act != val) begin
         bad++;
         $display("FAIL %s sel=%0d actual=%0d expected=%0d", tag, sel, act, val);
      end
   endtask

   // monitor: compares every entry due in the current cycle
   always @(negedge clk) begin
      exp_t keep[$];
      keep = {};
      foreach (sb_q[i]) begin
         if (sb_q[i].at <= cyc) begin
            int act;
            act = probe(sb_q[i].sel);
            total++;
            if (act != sb_q[i].val || sb_q[i].at != cyc) begin
               bad++;
               $display("FAIL %s sel=%0d cycle=%0d actual=%0d expected=%0d",
                        sb_q[i].tag, sb_q[i].sel, cyc, act, sb_q[i].val);
            end
         end else begin
            keep.push_back(sb_q[i]);
         end
      end
      sb_q = keep;
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ext_low = 1'b0; supply_fail = 1'b0; supply_good = 1'b0;
      sw_store = 1'b0; sw_recall = 1'b0; ase_on = 1'b0; ase_off = 1'b0; wr_done = 1'b0;
      step(3);
      // R1 reset state
      check_now(0, 6, "R1");
      check_now(1, 1, "R1");
      check_now(2, 0, "R1");
      check_now(3, 0, "R1");
      rst_n = 1'b1;
      expect_at(3, 0, 6, "R1");
      step(5);

      // R2 power-up recall
      supply_good = 1'b1;
      expect_at(1, 0, 7, "R2");
      expect_at(1, 4, 2, "R2");
      expect_at(1, 5, 1, "R2");
      expect_at(1, 2, 1, "R2");
      expect_at(2, 5, 0, "R2");
      expect_at(1 + CLR, 0, 8, "R2");
      expect_at(1 + CLR, 4, 3, "R2");
      expect_at(1 + CLR, 5, 1, "R2");
      expect_at(CLR + LDC, 0, 8, "R2");
      expect_at(1 + CLR + LDC, 6, 1, "R2");
      expect_at(1 + CLR + LDC, 2, 0, "R2");
      expect_at(1 + CLR + LDC, 0, 4, "R11");
      expect_at(3 + CLR + LDC, 1, 1, "R12");
      expect_at(4 + CLR + LDC, 0, 0, "R11");
      expect_at(4 + CLR + LDC, 1, 0, "R12");
      expect_at(6 + CLR + LDC, 0, 0, "R11");
      drain();

      // R5 outside pull while clean
      ext_low = 1'b1;
      expect_at(SYN + 1, 0, 5, "R5");
      expect_at(SYN + 1, 2, 0, "R5");
      expect_at(SYN + 1, 3, 0, "R5");
      expect_at(SYN + 1, 1, 1, "R12");
      step(10);
      ext_low = 1'b0;
      expect_at(SYN, 0, 5, "R5");
      expect_at(SYN + 1, 0, 0, "R5");
      drain();

      // R4 hardware store after a write (R3 sets dirty)
      wr_done = 1'b1;
      step(1);
      wr_done = 1'b0;
      step(1);
      ext_low = 1'b1;
      expect_at(SYN + 1, 0, 1, "R3");
      expect_at(SYN + 1, 2, 1, "R4");
      expect_at(SYN + DLY, 0, 1, "R4");
      expect_at(SYN + DLY + 1, 0, 2, "R4");
      expect_at(SYN + DLY + 1, 4, 1, "R4");
      expect_at(SYN + DLY + 1, 5, 1, "R4");
      expect_at(SYN + DLY + STO, 0, 2, "R4");
      expect_at(SYN + DLY + STO + 1, 0, 3, "R7");
      expect_at(SYN + DLY + STO + 1, 3, 1, "R7");
      expect_at(SYN + DLY + STO + 1, 2, 0, "R7");
      expect_at(SYN + DLY + STO + 1, 6, 1, "R4");
      expect_at(SYN + DLY + STO + HHI, 3, 1, "R7");
      expect_at(SYN + DLY + STO + HHI + 1, 0, 4, "R8");
      expect_at(SYN + DLY + STO + HHI + 1, 3, 0, "R7");
      expect_at(98, 0, 4, "R8");
      step(100);
      ext_low = 1'b0;
      expect_at(SYN, 0, 4, "R8");
      expect_at(SYN + 1, 0, 0, "R8");
      drain();

      // R3 dirty cleared by the store: outside pull now leads to state 5
      ext_low = 1'b1;
      expect_at(SYN + 1, 0, 5, "R3");
      step(5);
      ext_low = 1'b0;
      expect_at(SYN + 1, 0, 0, "R3");
      drain();

      // R6 software store with the dirty flag clear
      sw_store = 1'b1;
      expect_at(1, 0, 1, "R6");
      expect_at(DLY + 1, 0, 2, "R6");
      expect_at(DLY + STO + 1, 0, 3, "R7");
      expect_at(DLY + STO + 1, 3, 1, "R7");
      expect_at(DLY + STO + HHI, 0, 3, "R7");
      expect_at(DLY + STO + HHI + 1, 0, 4, "R7");
      expect_at(DLY + STO + HHI + 1, 3, 0, "R7");
      expect_at(DLY + STO + HHI + 2, 0, 0, "R11");
      step(1);
      sw_store = 1'b0;
      drain();

      // R9 automatic store with the enable at its reset value (R10)
      wr_done = 1'b1;
      step(1);
      wr_done = 1'b0;
      step(1);
      supply_fail = 1'b1; supply_good = 1'b0;
      expect_at(1, 0, 1, "R10");
      expect_at(1, 2, 1, "R9");
      expect_at(DLY + 1, 0, 2, "R9");
      expect_at(DLY + STO, 0, 2, "R9");
      expect_at(DLY + STO + 1, 0, 6, "R9");
      expect_at(DLY + STO + 1, 3, 0, "R9");
      expect_at(DLY + STO + 1, 6, 1, "R9");
      step(DLY + STO + 6);
      supply_fail = 1'b0; supply_good = 1'b1;
      expect_at(1, 0, 7, "R2");
      expect_at(CLR + LDC + 4, 0, 0, "R2");
      drain();

      // R10 enable cleared: dirty but no automatic store
      ase_off = 1'b1;
      step(1);
      ase_off = 1'b0;
      wr_done = 1'b1;
      step(1);
      wr_done = 1'b0;
      step(1);
      supply_fail = 1'b1; supply_good = 1'b0;
      expect_at(1, 0, 6, "R10");
      expect_at(1, 2, 0, "R10");
      step(6);
      supply_fail = 1'b0; supply_good = 1'b1;
      expect_at(1, 0, 7, "R2");
      expect_at(CLR + LDC + 4, 0, 0, "R2");
      drain();

      // R9 enable set again but clean after recall: no automatic store
      ase_on = 1'b1;
      step(1);
      ase_on = 1'b0;
      step(1);
      supply_fail = 1'b1; supply_good = 1'b0;
      expect_at(1, 0, 6, "R9");
      step(4);
      supply_fail = 1'b0; supply_good = 1'b1;
      expect_at(CLR + LDC + 4, 0, 0, "R2");
      drain();

      // R13 software recall
      sw_recall = 1'b1;
      expect_at(1, 0, 7, "R13");
      expect_at(1, 4, 2, "R13");
      expect_at(CLR + 1, 0, 8, "R13");
      expect_at(CLR + LDC + 1, 6, 1, "R13");
      expect_at(CLR + LDC + 4, 0, 0, "R13");
      step(1);
      sw_recall = 1'b0;
      drain();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule